// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit decides conditional branches while they sit in the decode stage of a five-stage pipeline with delayed-branch semantics. It takes the branch kind (equal or not-equal), the two register operands read from the register file with their indices, the sign-extended offset and the already incremented PC. It also takes the destination information of the instructions now in the execute, memory and writeback stages. From these it produces the next fetch address, a PC-select strobe and a decode stall.

Because the compare happens two stages earlier than the ALU, the unit carries its own forwarding muxes for each operand. One path takes the ALU result held by the instruction in the memory stage. The other takes the value the writeback stage is about to commit, which is how load data arrives. A producer whose result does not exist yet holds decode: any writer in execute, or a load in memory. The instruction fetched behind a resolved branch is the delay slot. It is never flushed, and the unit treats it as ordinary work. Once the branch leaves decode it needs nothing from later stages.

Top module: `br_resolve_unit`

## Requirements
- R1: When the branch kind is not equal (code 1) or not-equal (code 2), pc_sel_o is 0, stall_o is 0 and next_pc_o equals pc_plus4_i.
- R2: An equal branch redirects when its two resolved operands match. A not-equal branch redirects when they differ. A branch that does not redirect drives pc_sel_o 0 and next_pc_o equal to pc_plus4_i.
- R3: On a redirect, next_pc_o equals pc_plus4_i plus offset_i shifted left by two. The offset is two's complement, so backward targets work.
- R4: Each operand is forwarded from its own muxes. A memory-stage non-load writer of that index (value mem_alu_res_i) wins. Otherwise a writeback-stage writer (value wb_val_i) is used. Otherwise the register-file value is used.
- R5: Register index 0 never matches a producer, for forwarding or for stalling.
- R6: An enabled execute-stage writer whose destination matches either operand index stalls decode. This holds for ALU ops and loads alike. A disabled writer does not stall.
- R7: An enabled memory-stage load matching either operand stalls decode. A memory-stage non-load match does not stall and is forwarded instead. A load directly ahead of the branch therefore costs two stall cycles, and one two instructions ahead costs one.
- R8: While stall_o is 1, pc_sel_o is 0 and next_pc_o equals pc_plus4_i.
- R9: In the cycle after a branch resolves, taken or not, the decode instruction is the delay slot. It gets pc_sel_o 0, stall_o 0 and next_pc_o pc_plus4_i, even if it is itself a branch.
- R10: Reset (rst_ni low, asynchronous) clears the delay-slot state, so a branch seen during or right after reset resolves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| br_kind_i | input | 2 | 0 none, 1 equal, 2 not-equal, 3 none |
| pc_plus4_i | input | XLEN | Address of the instruction after the branch |
| offset_i | input | XLEN | Sign-extended word offset |
| rs_idx_i | input | RIDX | First operand register index |
| rt_idx_i | input | RIDX | Second operand register index |
| rs_val_i | input | XLEN | First operand from register file |
| rt_val_i | input | XLEN | Second operand from register file |
| ex_wen_i | input | 1 | Execute-stage instruction writes a register |
| ex_rd_i | input | RIDX | Execute-stage destination |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| mem_rd_i | input | RIDX | Memory-stage destination |
| mem_alu_res_i | input | XLEN | ALU result held by the memory-stage instruction |
| wb_wen_i | input | 1 | Writeback-stage instruction writes a register |
| wb_rd_i | input | RIDX | Writeback-stage destination |
| wb_val_i | input | XLEN | Value being written back |
| next_pc_o | output | XLEN | Next fetch address |
| pc_sel_o | output | 1 | 1 selects the branch target |
| stall_o | output | 1 | Hold decode and fetch |

## Verification
The bench aims at forwarding priority: a memory-stage writer and a writeback writer of the same register carry values that disagree. A mux ordered the wrong way flips the branch outcome. A load directly ahead of the branch is walked through two stall cycles and then resolved on the writeback value. A design that counted the memory-stage load as forwardable would resolve one cycle early on stale data. Register 0 producers, disabled writers and non-load memory producers are offered and must not stall. A branch placed in the delay slot, and a reset applied right after a resolved branch, show whether the slot tracking drops the second branch only when it should.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {
    BR_NONE = 2'd0,
    BR_EQ   = 2'd1,
    BR_NE   = 2'd2,
    BR_RSVD = 2'd3
  } br_kind_e;

  localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/br_opnd_fwd.sv
module br_opnd_fwd #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RIDX = 5
) (
  input  logic [RIDX-1:0] idx_i,
  input  logic [XLEN-1:0] rf_val_i,
  input  logic            mem_wen_i,
  input  logic            mem_load_i,
  input  logic [RIDX-1:0] mem_rd_i,
  input  logic [XLEN-1:0] mem_val_i,
  input  logic            wb_wen_i,
  input  logic [RIDX-1:0] wb_rd_i,
  input  logic [XLEN-1:0] wb_val_i,
  output logic [XLEN-1:0] val_o
);
  logic idx_live, mem_hit, wb_hit;

  always_comb begin
    idx_live = (idx_i != '0);
    mem_hit  = idx_live && mem_wen_i && !mem_load_i && (mem_rd_i == idx_i);
    wb_hit   = idx_live && wb_wen_i && (wb_rd_i == idx_i);
    if (mem_hit)     val_o = mem_val_i;
    else if (wb_hit) val_o = wb_val_i;
    else             val_o = rf_val_i;
  end
endmodule

// File: rtl/br_hazard.sv
module br_hazard #(
  parameter int unsigned RIDX = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0][RIDX-1:0] src_idx_i,
  input  logic                      ex_wen_i,
  input  logic [RIDX-1:0]           ex_rd_i,
  input  logic                      mem_wen_i,
  input  logic                      mem_load_i,
  input  logic [RIDX-1:0]           mem_rd_i,
  output logic                      busy_o
);
  logic [NSRC-1:0] src_busy;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic live, ex_hit, ld_hit;
    always_comb begin
      live   = (src_idx_i[g] != '0);
      // execute result only exists after this cycle
      ex_hit = live && ex_wen_i && (ex_rd_i == src_idx_i[g]);
      // load data only exists after the memory stage
      ld_hit = live && mem_wen_i && mem_load_i && (mem_rd_i == src_idx_i[g]);
      src_busy[g] = ex_hit || ld_hit;
    end
  end

  assign busy_o = |src_busy;
endmodule

// File: rtl/br_decide.sv
module br_decide
  import br_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  br_kind_e        kind_i,
  input  logic [XLEN-1:0] opnd_a_i,
  input  logic [XLEN-1:0] opnd_b_i,
  input  logic [XLEN-1:0] pc_plus4_i,
  input  logic [XLEN-1:0] offset_i,
  output logic            taken_o,
  output logic [XLEN-1:0] target_o
);
  logic same;

  always_comb begin
    same = (opnd_a_i == opnd_b_i);
    unique case (kind_i)
      BR_EQ:   taken_o = same;
      BR_NE:   taken_o = !same;
      default: taken_o = 1'b0;
    endcase
    target_o = pc_plus4_i + {offset_i[XLEN-3:0], 2'b00};
  end
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
  import br_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RIDX = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      br_kind_i,
  input  logic [XLEN-1:0] pc_plus4_i,
  input  logic [XLEN-1:0] offset_i,
  input  logic [RIDX-1:0] rs_idx_i,
  input  logic [RIDX-1:0] rt_idx_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  input  logic            ex_wen_i,
  input  logic [RIDX-1:0] ex_rd_i,
  input  logic            mem_wen_i,
  input  logic            mem_load_i,
  input  logic [RIDX-1:0] mem_rd_i,
  input  logic [XLEN-1:0] mem_alu_res_i,
  input  logic            wb_wen_i,
  input  logic [RIDX-1:0] wb_rd_i,
  input  logic [XLEN-1:0] wb_val_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            pc_sel_o,
  output logic            stall_o
);
  br_kind_e kind;
  logic [NUM_OPND-1:0][RIDX-1:0] opnd_idx;
  logic [NUM_OPND-1:0][XLEN-1:0] opnd_rf, opnd_val;
  logic            is_branch, active, busy, resolve, taken;
  logic            slot_q;
  logic [XLEN-1:0] target;

  assign kind        = br_kind_e'(br_kind_i);
  assign opnd_idx[0] = rs_idx_i;
  assign opnd_idx[1] = rt_idx_i;
  assign opnd_rf[0]  = rs_val_i;
  assign opnd_rf[1]  = rt_val_i;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_fwd
    br_opnd_fwd #(.XLEN(XLEN), .RIDX(RIDX)) i_fwd (
      .idx_i      (opnd_idx[g]),
      .rf_val_i   (opnd_rf[g]),
      .mem_wen_i  (mem_wen_i),
      .mem_load_i (mem_load_i),
      .mem_rd_i   (mem_rd_i),
      .mem_val_i  (mem_alu_res_i),
      .wb_wen_i   (wb_wen_i),
      .wb_rd_i    (wb_rd_i),
      .wb_val_i   (wb_val_i),
      .val_o      (opnd_val[g])
    );
  end

  br_hazard #(.RIDX(RIDX), .NSRC(NUM_OPND)) i_hazard (
    .src_idx_i  (opnd_idx),
    .ex_wen_i   (ex_wen_i),
    .ex_rd_i    (ex_rd_i),
    .mem_wen_i  (mem_wen_i),
    .mem_load_i (mem_load_i),
    .mem_rd_i   (mem_rd_i),
    .busy_o     (busy)
  );

  br_decide #(.XLEN(XLEN)) i_decide (
    .kind_i     (kind),
    .opnd_a_i   (opnd_val[0]),
    .opnd_b_i   (opnd_val[1]),
    .pc_plus4_i (pc_plus4_i),
    .offset_i   (offset_i),
    .taken_o    (taken),
    .target_o   (target)
  );

  always_comb begin
    is_branch = (kind == BR_EQ) || (kind == BR_NE);
    // delay-slot instruction is never treated as a branch
    active    = is_branch && !slot_q;
    stall_o   = active && busy;
    resolve   = active && !busy;
    pc_sel_o  = resolve && taken;
    next_pc_o = pc_sel_o ? target : pc_plus4_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= 1'b0;
    else         slot_q <= resolve;
  end
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      br_kind_i,
  input logic [XLEN-1:0] pc_plus4_i,
  input logic [XLEN-1:0] offset_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic            pc_sel_o,
  input logic            stall_o,
  input logic            slot_q
);
  logic is_br;
  assign is_br = (br_kind_i == 2'd1) || (br_kind_i == 2'd2);

  assert_no_branch_falls_through_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_br |-> (!pc_sel_o && !stall_o && next_pc_o == pc_plus4_i));

  assert_redirect_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_sel_o |-> (next_pc_o == pc_plus4_i + {offset_i[XLEN-3:0], 2'b00}));

  assert_stall_only_for_branch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> is_br);

  assert_no_redirect_in_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!pc_sel_o && next_pc_o == pc_plus4_i));

  assert_slot_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_br && !stall_o && !slot_q) |=> (!pc_sel_o && !stall_o));
endmodule

bind br_resolve_unit br_resolve_chk #(.XLEN(XLEN)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .br_kind_i  (br_kind_i),
  .pc_plus4_i (pc_plus4_i),
  .offset_i   (offset_i),
  .next_pc_o  (next_pc_o),
  .pc_sel_o   (pc_sel_o),
  .stall_o    (stall_o),
  .slot_q     (slot_q)
);

// File: tb/test_br_resolve_unit.sv
module test_br_resolve_unit;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  typedef struct {
    logic [1:0]      kind;
    logic [XLEN-1:0] pc4, off;
    logic [RIDX-1:0] rs, rt;
    logic [XLEN-1:0] rsv, rtv;
    logic            ex_wen;
    logic [RIDX-1:0] ex_rd;
    logic            mem_wen, mem_load;
    logic [RIDX-1:0] mem_rd;
    logic [XLEN-1:0] mem_res;
    logic            wb_wen;
    logic [RIDX-1:0] wb_rd;
    logic [XLEN-1:0] wb_val;
  } stim_t;

  typedef struct {
    logic            sel, stl;
    logic [XLEN-1:0] pc;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  stim_t cur, nx;
  exp_t  sb[$];
  int total = 0, bad = 0;
  bit done = 0;

  logic [XLEN-1:0] next_pc;
  logic pc_sel, stall;

  always #4 clk = ~clk;

  br_resolve_unit #(.XLEN(XLEN), .RIDX(RIDX)) i_br_resolve_unit (
    .clk_i(clk), .rst_ni(rst_ni), .br_kind_i(cur.kind), .pc_plus4_i(cur.pc4),
    .offset_i(cur.off), .rs_idx_i(cur.rs), .rt_idx_i(cur.rt),
    .rs_val_i(cur.rsv), .rt_val_i(cur.rtv), .ex_wen_i(cur.ex_wen),
    .ex_rd_i(cur.ex_rd), .mem_wen_i(cur.mem_wen), .mem_load_i(cur.mem_load),
    .mem_rd_i(cur.mem_rd), .mem_alu_res_i(cur.mem_res), .wb_wen_i(cur.wb_wen),
    .wb_rd_i(cur.wb_rd), .wb_val_i(cur.wb_val), .next_pc_o(next_pc),
    .pc_sel_o(pc_sel), .stall_o(stall)
  );

  task automatic clr();
    nx.ex_wen = 0; nx.ex_rd = '0; nx.mem_wen = 0; nx.mem_load = 0; nx.mem_rd = '0;
    nx.mem_res = '0; nx.wb_wen = 0; nx.wb_rd = '0; nx.wb_val = '0;
  endtask

  task automatic br(input logic [1:0] k, input logic [RIDX-1:0] a, input logic [RIDX-1:0] b,
                    input logic [XLEN-1:0] av, input logic [XLEN-1:0] bv);
    nx.kind = k; nx.rs = a; nx.rt = b; nx.rsv = av; nx.rtv = bv;
  endtask

  // driver: apply staged stimulus at negedge, push expectation
  task automatic step(input logic sel, input logic stl, input logic [XLEN-1:0] pc, input string tag);
    exp_t e;
    @(negedge clk);
    cur = nx;
    e.sel = sel; e.stl = stl; e.pc = pc; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: sample away from the edge, pop and compare
  initial forever begin
    @(negedge clk);
    #2;
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (pc_sel !== e.sel || stall !== e.stl || next_pc !== e.pc) begin
        bad++;
        $display("FAIL %s: got sel=%0b stall=%0b pc=%h, exp sel=%0b stall=%0b pc=%h",
                 e.tag, pc_sel, stall, next_pc, e.sel, e.stl, e.pc);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung, exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [XLEN-1:0] PC4 = 32'h0000_1004;
  localparam logic [1:0] K_NONE = 2'd0, K_EQ = 2'd1, K_NE = 2'd2, K_RSV = 2'd3;

  initial begin
    nx.pc4 = PC4; nx.off = 32'd3; clr(); br(K_NONE, 5'd1, 5'd2, 0, 0);
    cur = nx;
    step(0, 0, PC4, "R1 reset state");
    @(negedge clk); rst_ni = 1'b1;

    br(K_EQ, 5'd1, 5'd2, 5, 5);
    step(1, 0, PC4 + 32'd12, "R2 R3 eq taken");
    step(0, 0, PC4, "R9 branch in slot of taken branch");
    br(K_EQ, 5'd1, 5'd2, 5, 6);
    step(0, 0, PC4, "R2 eq not taken");
    br(K_NE, 5'd1, 5'd2, 5, 6);
    step(0, 0, PC4, "R9 slot after not-taken branch");
    nx.off = 32'hFFFF_FFFE;
    step(1, 0, PC4 - 32'd8, "R2 R3 ne taken backward");
    br(K_NONE, 5'd1, 5'd2, 5, 6);
    step(0, 0, PC4, "R1 none");
    br(K_NE, 5'd1, 5'd2, 7, 7);
    step(0, 0, PC4, "R2 ne not taken");
    br(K_RSV, 5'd1, 5'd2, 7, 8);
    step(0, 0, PC4, "R1 reserved code");
    nx.off = 32'd4;

    // R4 mem forwarding
    br(K_EQ, 5'd3, 5'd4, 1, 9); nx.mem_wen = 1; nx.mem_rd = 5'd3; nx.mem_res = 9;
    step(1, 0, PC4 + 32'd16, "R4 mem-stage forward");
    br(K_NONE, 5'd3, 5'd4, 0, 0); clr();
    step(0, 0, PC4, "R1 none");
    // R4 priority mem over wb
    br(K_EQ, 5'd3, 5'd4, 0, 9); nx.mem_wen = 1; nx.mem_rd = 5'd3; nx.mem_res = 9;
    nx.wb_wen = 1; nx.wb_rd = 5'd3; nx.wb_val = 1;
    step(1, 0, PC4 + 32'd16, "R4 mem beats wb");
    br(K_NONE, 5'd3, 5'd4, 0, 0); clr();
    step(0, 0, PC4, "R1 none");
    // R4 wb forwarding
    br(K_EQ, 5'd3, 5'd4, 1, 9); nx.wb_wen = 1; nx.wb_rd = 5'd4; nx.wb_val = 1;
    step(1, 0, PC4 + 32'd16, "R4 wb forward");
    br(K_NONE, 5'd3, 5'd4, 0, 0); clr();
    step(0, 0, PC4, "R1 none");
    // R5 register zero
    br(K_EQ, 5'd0, 5'd4, 0, 0); nx.ex_wen = 1; nx.ex_rd = 5'd0;
    nx.mem_wen = 1; nx.mem_rd = 5'd0; nx.mem_res = 5;
    step(1, 0, PC4 + 32'd16, "R5 r0 no stall no forward");
    br(K_NONE, 5'd3, 5'd4, 0, 0); clr();
    step(0, 0, PC4, "R1 none");
    // R6 ALU directly ahead: one stall
    br(K_EQ, 5'd2, 5'd4, 3, 3); nx.ex_wen = 1; nx.ex_rd = 5'd2;
    step(0, 1, PC4, "R6 R8 ex alu stall");
    clr(); nx.mem_wen = 1; nx.mem_rd = 5'd2; nx.mem_res = 3;
    step(1, 0, PC4 + 32'd16, "R6 resolves after one stall");
    br(K_NONE, 5'd3, 5'd4, 0, 0); clr();
    step(0, 0, PC4, "R1 none");
    // R7 load directly ahead: two stalls
    br(K_NE, 5'd2, 5'd4, 1, 1); nx.ex_wen = 1; nx.ex_rd = 5'd4;
    step(0, 1, PC4, "R6 ex load stall");
    clr(); nx.mem_wen = 1; nx.mem_load = 1; nx.mem_rd = 5'd4; nx.mem_res = 1;
    step(0, 1, PC4, "R7 R8 mem load stall");
    clr(); nx.wb_wen = 1; nx.wb_rd = 5'd4; nx.wb_val = 8;
    step(1, 0, PC4 + 32'd16, "R7 R4 resolves on load data");
    br(K_NONE, 5'd3, 5'd4, 0, 0); clr();
    step(0, 0, PC4, "R1 none");
    // R7 mem non-load: forward, no stall
    br(K_EQ, 5'd2, 5'd4, 1, 2); nx.mem_wen = 1; nx.mem_rd = 5'd4; nx.mem_res = 1;
    step(1, 0, PC4 + 32'd16, "R7 mem alu no stall");
    br(K_NONE, 5'd3, 5'd4, 0, 0); clr();
    step(0, 0, PC4, "R1 none");
    // R6 disabled writer
    br(K_EQ, 5'd2, 5'd4, 6, 6); nx.ex_rd = 5'd2;
    step(1, 0, PC4 + 32'd16, "R6 disabled writer no stall");
    br(K_NONE, 5'd3, 5'd4, 0, 0); clr();
    step(0, 0, PC4, "R1 none");
    // R10 reset clears slot state
    br(K_EQ, 5'd1, 5'd2, 4, 4);
    step(1, 0, PC4 + 32'd16, "R10 branch before reset");
    #3 rst_ni = 1'b0;
    step(1, 0, PC4 + 32'd16, "R10 slot cleared by reset");
    #3 rst_ni = 1'b1;
    step(0, 0, PC4, "R9 slot after reset branch");
    br(K_NONE, 5'd3, 5'd4, 0, 0);
    step(0, 0, PC4, "R1 none");

    @(negedge clk); #4;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule